// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block is the purely combinational front of a small processor's control unit. It takes one 16-bit instruction word and produces the control word for a register-file and ALU datapath. The control word holds the three register selects, the ALU function code, the operand-B and write-back source selects, the register and memory write enables, and a sign-extended constant. For control flow it raises a jump flag or a branch flag and passes a 3-bit branch condition code on to the program-counter logic. The caller presents a word on `instr` and reads the decoded fields in the same cycle.

The top three bits of the instruction pick one of eight categories. Each category sets a fixed pattern of datapath selects and enables. In the ALU categories, the next four bits pass straight through to the low bits of the function code. The three formats share their field positions, so register selects and the constant are taken from fixed bit positions for every word. Only the category decides which outputs matter. Any opcode the category does not define decodes to a safe word: nothing is written and no control transfer happens.

Top module: `instr_decoder`

## Requirements
- R1: For every word, `dst_sel` = instr[8:6], `srca_sel` = instr[5:3] and `srcb_sel` = instr[2:0].
- R2: Category instr[15:13]=000 (register ALU) gives b_from_const=0, d_from_mem=0, reg_wr=1, mem_wr=0, alu_func = {0, instr[12:9]}, no jump, no branch.
- R3: Category 100 (immediate ALU) gives b_from_const=1, d_from_mem=0, reg_wr=1, mem_wr=0, alu_func = {0, instr[12:9]}. For every category except 110 and 111, `const_out` is instr[2:0] sign-extended to DATA_W bits.
- R4: Category 101 (immediate shift) gives b_from_const=1, d_from_mem=0, reg_wr=1, mem_wr=0, alu_func = {1, instr[12:9]}.
- R5: Category 001 with instr[12:9]=0000 (store) gives mem_wr=1, reg_wr=0, b_from_const=0, d_from_mem=0, alu_func=00000.
- R6: Category 010 with instr[12:9]=0000 (load from memory) gives reg_wr=1, d_from_mem=1, b_from_const=0, mem_wr=0, alu_func=00000.
- R7: Category 011 with instr[12:9]=0000 (load constant) gives reg_wr=1, b_from_const=1, d_from_mem=0, mem_wr=0, alu_func=10000 (pass operand B).
- R8: Category 110 with instr[12]=0 (branch) gives is_branch=1, br_cond = instr[11:9], reg_wr=0, mem_wr=0, alu_func=00000. For categories 110 and 111, `const_out` is the 6-bit offset {instr[8:6], instr[2:0]} sign-extended, covering -32 to +31.
- R9: Category 111 with instr[12:9]=0000 (jump) gives is_jump=1, is_branch=0, reg_wr=0, mem_wr=0.
- R10: Undefined opcodes are categories 001, 010, 011 and 111 with instr[12:9]≠0000, and category 110 with instr[12]=1. They give reg_wr=0, mem_wr=0, is_jump=0, is_branch=0, b_from_const=0, d_from_mem=0, alu_func=00000 and br_cond=000.
- R11: reg_wr and mem_wr are never both 1, and is_jump and is_branch are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| dst_sel | output | 3 | Destination register select |
| srca_sel | output | 3 | Operand A register select |
| srcb_sel | output | 3 | Operand B register select |
| b_from_const | output | 1 | Operand B taken from the constant |
| alu_func | output | 5 | ALU function code |
| d_from_mem | output | 1 | Write-back data taken from memory |
| reg_wr | output | 1 | Register file write enable |
| mem_wr | output | 1 | Data memory write enable |
| const_out | output | DATA_W | Sign-extended immediate or offset |
| is_jump | output | 1 | Unconditional jump |
| is_branch | output | 1 | Conditional branch |
| br_cond | output | 3 | Branch condition code |

## Verification
Hand-picked words come first. They cover each category with a typical opcode, the extreme branch offsets +31 and -32, immediates -4 and +3, and the undefined sub-codes next to each defined one. These separate a wrong category pattern from a wrong field slice or a missing sign extension. An exhaustive pass over all 65536 instruction words follows. It shows that the undefined-opcode rule holds across the whole space. It also shows that bits which should not matter, such as the register fields within jumps, never change the enables.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int INSTR_W = 16;
  localparam int REG_AW  = 3;
  localparam int FS_W    = 5;
  localparam int COND_W  = 3;
  localparam int SUB_W   = 4;
  localparam int IMM_W   = 3;
  localparam int OFS_W   = 2 * IMM_W;
  localparam logic [FS_W-1:0] FS_PASS_B = 5'b10000;

  typedef enum logic [2:0] {
    CAT_REG_ALU   = 3'b000,
    CAT_STORE     = 3'b001,
    CAT_LOAD      = 3'b010,
    CAT_LDCONST   = 3'b011,
    CAT_IMM_ALU   = 3'b100,
    CAT_IMM_SHIFT = 3'b101,
    CAT_BRANCH    = 3'b110,
    CAT_JUMP      = 3'b111
  } category_e;

  typedef struct packed {
    logic              b_from_const;
    logic              d_from_mem;
    logic              reg_wr;
    logic              mem_wr;
    logic [FS_W-1:0]   alu_func;
    logic              is_jump;
    logic              is_branch;
    logic [COND_W-1:0] br_cond;
  } ctrl_word_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import instr_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output category_e          cat,
  output logic [SUB_W-1:0]   sub,
  output logic [REG_AW-1:0]  dst,
  output logic [REG_AW-1:0]  sa,
  output logic [REG_AW-1:0]  sb,
  output logic [OFS_W-1:0]   offset
);
  always_comb begin
    cat    = category_e'(instr[15:13]);
    sub    = instr[12:9];
    dst    = instr[8:6];
    sa     = instr[5:3];
    sb     = instr[2:0];
    offset = {instr[8:6], instr[2:0]};
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import instr_dec_pkg::*;
(
  input  category_e        cat,
  input  logic [SUB_W-1:0] sub,
  output ctrl_word_t       cw
);
  logic sub_zero;
  assign sub_zero = (sub == '0);

  always_comb begin
    cw = '0;
    unique case (cat)
      CAT_REG_ALU: begin
        cw.reg_wr   = 1'b1;
        cw.alu_func = {1'b0, sub};
      end
      CAT_STORE: begin
        cw.mem_wr = sub_zero;
      end
      CAT_LOAD: begin
        cw.reg_wr     = sub_zero;
        cw.d_from_mem = sub_zero;
      end
      CAT_LDCONST: begin
        cw.reg_wr       = sub_zero;
        cw.b_from_const = sub_zero;
        cw.alu_func     = sub_zero ? FS_PASS_B : '0;
      end
      CAT_IMM_ALU: begin
        cw.reg_wr       = 1'b1;
        cw.b_from_const = 1'b1;
        cw.alu_func     = {1'b0, sub};
      end
      CAT_IMM_SHIFT: begin
        cw.reg_wr       = 1'b1;
        cw.b_from_const = 1'b1;
        cw.alu_func     = {1'b1, sub};
      end
      CAT_BRANCH: begin
        cw.is_branch = ~sub[SUB_W-1];
        cw.br_cond   = sub[SUB_W-1] ? '0 : sub[COND_W-1:0];
      end
      CAT_JUMP: begin
        cw.is_jump = sub_zero;
      end
      default: cw = '0;
    endcase
  end

  // R11: exclusive enables and exclusive control-flow flags
  always_comb begin
    a_r11_wr_excl: assert (!(cw.reg_wr && cw.mem_wr))
      else $error("reg and mem write together");
    a_r11_flow_excl: assert (!(cw.is_jump && cw.is_branch))
      else $error("jump and branch together");
  end

  // R10: a word with no effect must also carry quiet selects
  always_comb begin
    if (!(cw.reg_wr || cw.mem_wr || cw.is_jump || cw.is_branch)) begin
      a_r10_quiet: assert (cw.alu_func == '0 && !cw.b_from_const && !cw.d_from_mem)
        else $error("inactive word with live selects");
    end
  end
endmodule

// File: rtl/idec_const.sv
module idec_const
  import instr_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [OFS_W-1:0]  offset,
  input  logic              use_offset,
  output logic [DATA_W-1:0] value
);
  localparam int IMM_PAD = DATA_W - IMM_W;
  localparam int OFS_PAD = DATA_W - OFS_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] ofs_ext;

  generate
    if (DATA_W > OFS_W) begin : g_extend
      assign imm_ext = {{IMM_PAD{imm[IMM_W-1]}}, imm};
      assign ofs_ext = {{OFS_PAD{offset[OFS_W-1]}}, offset};
    end else begin : g_exact
      assign imm_ext = DATA_W'(signed'(imm));
      assign ofs_ext = offset[DATA_W-1:0];
    end
  endgenerate

  assign value = use_offset ? ofs_ext : imm_ext;
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [15:0]       instr,
  output logic [2:0]        dst_sel,
  output logic [2:0]        srca_sel,
  output logic [2:0]        srcb_sel,
  output logic              b_from_const,
  output logic [4:0]        alu_func,
  output logic              d_from_mem,
  output logic              reg_wr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] const_out,
  output logic              is_jump,
  output logic              is_branch,
  output logic [2:0]        br_cond
);
  category_e         cat;
  logic [SUB_W-1:0]  sub;
  logic [OFS_W-1:0]  offset;
  ctrl_word_t        cw;

  idec_fields u_fields (
    .instr  (instr),
    .cat    (cat),
    .sub    (sub),
    .dst    (dst_sel),
    .sa     (srca_sel),
    .sb     (srcb_sel),
    .offset (offset)
  );

  idec_ctrl u_ctrl (
    .cat (cat),
    .sub (sub),
    .cw  (cw)
  );

  idec_const #(.DATA_W(DATA_W)) u_const (
    .imm        (srcb_sel),
    .offset     (offset),
    .use_offset (cat == CAT_BRANCH || cat == CAT_JUMP),
    .value      (const_out)
  );

  assign b_from_const = cw.b_from_const;
  assign alu_func     = cw.alu_func;
  assign d_from_mem   = cw.d_from_mem;
  assign reg_wr       = cw.reg_wr;
  assign mem_wr       = cw.mem_wr;
  assign is_jump      = cw.is_jump;
  assign is_branch    = cw.is_branch;
  assign br_cond      = cw.br_cond;

  // R8 / R9: control-flow offsets stay within the 6-bit signed range
  always_comb begin
    if (is_branch || is_jump) begin
      a_r8_offset_ext: assert (const_out[DATA_W-1:OFS_W-1] == {(DATA_W-OFS_W+1){const_out[OFS_W-1]}})
        else $error("offset not sign-extended");
    end
  end

  // R3: a constant operand fits the 3-bit signed range
  always_comb begin
    if (b_from_const) begin
      a_r3_imm_ext: assert (const_out[DATA_W-1:IMM_W-1] == {(DATA_W-IMM_W+1){const_out[IMM_W-1]}})
        else $error("immediate not sign-extended");
    end
  end

  // R5: a store reads its data from the register file and writes no register
  always_comb begin
    if (mem_wr) begin
      a_r5_store_src: assert (!b_from_const && !reg_wr && !d_from_mem)
        else $error("store with wrong selects");
    end
  end
endmodule

// File: tb/sim_instr_decoder.sv
module sim_instr_decoder;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  always #4ns clk = ~clk;

  logic [15:0]       instr;
  logic [2:0]        dst_sel, srca_sel, srcb_sel, br_cond;
  logic              b_from_const, d_from_mem, reg_wr, mem_wr, is_jump, is_branch;
  logic [4:0]        alu_func;
  logic [DATA_W-1:0] const_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  instr_decoder #(.DATA_W(DATA_W)) u0 (
    .instr(instr), .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .b_from_const(b_from_const), .alu_func(alu_func), .d_from_mem(d_from_mem),
    .reg_wr(reg_wr), .mem_wr(mem_wr), .const_out(const_out),
    .is_jump(is_jump), .is_branch(is_branch), .br_cond(br_cond)
  );

  // packed order: mb md wr mw fs[4:0] jump branch cond[2:0]
  function automatic logic [13:0] model_ctl(input logic [15:0] w, output string tag);
    int cat = int'(w[15:13]);
    int sub = int'(w[12:9]);
    logic mb = 0, md = 0, wr = 0, mw = 0, j = 0, b = 0;
    logic [4:0] fs = 0;
    logic [2:0] c = 0;
    tag = "R10";
    case (cat)
      0: begin wr = 1; fs = 5'(sub); tag = "R2"; end
      1: if (sub == 0) begin mw = 1; tag = "R5"; end
      2: if (sub == 0) begin wr = 1; md = 1; tag = "R6"; end
      3: if (sub == 0) begin wr = 1; mb = 1; fs = 5'd16; tag = "R7"; end
      4: begin wr = 1; mb = 1; fs = 5'(sub); tag = "R3"; end
      5: begin wr = 1; mb = 1; fs = 5'(sub + 16); tag = "R4"; end
      6: if (sub < 8) begin b = 1; c = 3'(sub); tag = "R8"; end
      default: if (sub == 0) begin j = 1; tag = "R9"; end
    endcase
    return {mb, md, wr, mw, fs, j, b, c};
  endfunction

  function automatic logic [DATA_W-1:0] model_const(input logic [15:0] w);
    int v;
    if (w[15:14] == 2'b11) begin
      v = int'(w[8:6]) * 8 + int'(w[2:0]);
      if (v >= 32) v = v - 64;
    end else begin
      v = int'(w[2:0]);
      if (v >= 4) v = v - 8;
    end
    return DATA_W'(v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s word=%04h actual=%0h expected=%0h", req, instr, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [15:0] w);
    string tag;
    logic [13:0] ec, ac;
    logic [DATA_W-1:0] ek;
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    ec = model_ctl(w, tag);
    ek = model_const(w);
    ac = {b_from_const, d_from_mem, reg_wr, mem_wr, alu_func, is_jump, is_branch, br_cond};
    check({dst_sel, srca_sel, srcb_sel} == w[8:0], "R1", {dst_sel, srca_sel, srcb_sel}, w[8:0]);
    check(ac == ec, tag, ac, ec);
    check(const_out == ek, (w[15:14] == 2'b11) ? "R8" : "R3", const_out, ek);
    check(!(reg_wr && mem_wr) && !(is_jump && is_branch), "R11", ac, ec);
  endtask

  task automatic expect_const(input string req, input int v);
    check(const_out == DATA_W'(v), req, const_out, DATA_W'(v));
  endtask

  initial begin
    instr = 16'h0000;
    repeat (2) @(posedge clk);
    // reset-state style check: all-zero word is a register ALU op with FS 0
    @(negedge clk);
    check(reg_wr && !mem_wr && alu_func == 5'd0, "R2", {reg_wr, mem_wr}, 2'b10);

    apply_and_check({3'b000, 4'b0010, 3'd1, 3'd2, 3'd3});          // R2 reg add
    apply_and_check({3'b100, 4'b1100, 3'd5, 3'd6, 3'b100});        // R3 imm, -4
    expect_const("R3", -4);
    apply_and_check({3'b100, 4'b0010, 3'd7, 3'd7, 3'b011});        // R3 +3
    expect_const("R3", 3);
    apply_and_check({3'b101, 4'b1000, 3'd2, 3'd3, 3'd1});          // R4 shift left
    check(alu_func == 5'b11000, "R4", alu_func, 5'b11000);
    apply_and_check({3'b001, 4'b0000, 3'd0, 3'd3, 3'd1});          // R5 store
    apply_and_check({3'b001, 4'b0001, 3'd0, 3'd3, 3'd1});          // R10 store sub!=0
    check(!mem_wr, "R10", mem_wr, 0);
    apply_and_check({3'b010, 4'b0000, 3'd1, 3'd3, 3'd0});          // R6 load
    apply_and_check({3'b011, 4'b0000, 3'd1, 3'd0, 3'b111});        // R7 load const -1
    expect_const("R7", -1);
    apply_and_check({3'b110, 4'b0011, 3'b101, 3'd3, 3'b000});      // R8 branch -24
    expect_const("R8", -24);
    apply_and_check({3'b110, 4'b0111, 3'b011, 3'd0, 3'b111});      // R8 +31
    expect_const("R8", 31);
    apply_and_check({3'b110, 4'b1011, 3'b100, 3'd0, 3'b000});      // R10 branch bit12, offset -32
    check(!is_branch && br_cond == 0, "R10", {is_branch, br_cond}, 0);
    apply_and_check({3'b111, 4'b0000, 3'b010, 3'd0, 3'b010});      // R9 jump 18
    expect_const("R9", 18);
    apply_and_check({3'b111, 4'b0100, 3'b010, 3'd0, 3'b010});      // R10 jump sub!=0
    check(!is_jump && !reg_wr, "R10", is_jump, 0);

    for (int w = 0; w < 65536; w++) apply_and_check(16'(w));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8ns * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule